// File: doc/BRIEF.md
# FIFO-level-driven burst DMA engine for an SPI controller

This block sits beside the transmit and receive FIFOs of an SPI controller and moves 64-bit words between those FIFOs and memory. Memory is reached through a request/acknowledge port. When the transmit FIFO runs low, the engine fetches a fixed-length block of words from memory and pushes each one into the FIFO. When the receive FIFO fills past a set level, it pops a fixed-length block of words and writes each one out to memory. Each direction has its own memory pointer, which moves forward by eight bytes for every word moved.

Software programs the following before setting the enable bit:
- the two pointers;
- the two FIFO-level thresholds;
- the two burst lengths;
- a count of bursts for each direction.

Each completed burst decrements the count of its direction. Once every counted direction reaches zero, the engine drops its enable by itself and pulses an end-of-transfer interrupt. Writing zero to the control register stops the engine. A memory beat already on the port is allowed to finish first.

Top module: `spi_fifo_dma`

## Requirements
- R1: After reset, `mem_req`, `dma_active`, `done_irq`, `tx_push` and `rx_pop` are all low.
- R2: A read burst starts when all of these hold: the engine is enabled, the read counter enable (control bit 7) is set, the read burst count is non-zero, and `tx_level` is strictly below the TX threshold. The burst performs exactly the programmed number of read beats. Each acknowledged beat pushes `mem_rdata` into the TX FIFO.
- R3: A write burst starts when all of these hold: the engine is enabled, the write counter enable (control bit 8) is set, the write burst count is non-zero, and `rx_level` is strictly above the RX threshold. Each acknowledged beat writes `rx_data` to memory and pops the RX FIFO.
- R4: The burst lengths are written as length minus one: read length in control bits 3:1, write length in bits 6:4. An encoded value of 0 (a one-word burst) never starts a burst in that direction.
- R5: The register at address 4 holds the TX threshold in bits 7:0 and the RX threshold in bits 15:8. The RX threshold resets to 31, so a 16-deep RX FIFO never triggers a write burst until software lowers it.
- R6: The register at address 1 holds the read burst count in bits 15:0 and the write burst count in bits 31:16. Address 2 is the read pointer, address 3 is the write pointer, and bit 0 of address 0 is the enable.
- R7: A pointer advances by 8 bytes for each acknowledged beat in its direction. It carries over across bursts and across separate runs until software rewrites it.
- R8: Each completed burst decrements its direction's count. When every enabled count is zero, `dma_active` falls and `done_irq` pulses high for exactly one cycle.
- R9: `mem_req` stays high with `mem_addr` and `mem_we` unchanged until `mem_ack`. Exactly one word moves per acknowledged cycle.
- R10: Writing zero to the control register lets the beat on the port complete and then starts no further beats. No `done_irq` is raised.
- R11: When both directions are eligible in the same cycle, the write (RX-draining) burst goes first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register index (0 control, 1 counts, 2 read pointer, 3 write pointer, 4 thresholds) |
| reg_wdata | input | 32 | Register write data |
| tx_level | input | 5 | Words held in the TX FIFO |
| rx_level | input | 5 | Words held in the RX FIFO |
| mem_req | output | 1 | Memory beat request |
| mem_we | output | 1 | 1 for a write beat, 0 for a read beat |
| mem_addr | output | 32 | Byte address of the beat |
| mem_wdata | output | 64 | Write beat data |
| mem_rdata | input | 64 | Read beat data |
| mem_ack | input | 1 | Beat accepted this cycle |
| tx_push | output | 1 | Push into the TX FIFO |
| tx_data | output | 64 | Word pushed into the TX FIFO |
| rx_pop | output | 1 | Pop from the RX FIFO |
| rx_data | input | 64 | Head word of the RX FIFO |
| dma_active | output | 1 | Engine enable state |
| done_irq | output | 1 | One-cycle end-of-transfer pulse |

## Verification
The transmit side is run with a FIFO that fills only through the engine's own pushes. This shows whether the threshold is re-evaluated after every burst and whether the burst count, rather than the fill level, ends the run. The receive side runs against a memory that acknowledges only every other request cycle, which separates a request that holds its address from one that runs ahead. Levels placed exactly at the threshold, an encoded length of zero and the reset RX threshold must each produce no traffic. With both FIFOs eligible at once, the order of the beats shows which direction was granted first. An abort issued between acknowledgements must let exactly one more beat through.

// File: rtl/spi_fifo_dma.sv
module spi_fifo_dma #(
  parameter int DEPTH      = 16,
  parameter int DW         = 64,
  parameter int AW         = 32,
  parameter int MAX_BURST  = 8,
  parameter int TW         = 8,
  parameter int CNTW       = 16,
  parameter int RX_THR_RST = 31,
  localparam int LW        = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr,
  input  logic [2:0]    reg_addr,
  input  logic [31:0]   reg_wdata,
  input  logic [LW-1:0] tx_level,
  input  logic [LW-1:0] rx_level,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata,
  input  logic          mem_ack,
  output logic          tx_push,
  output logic [DW-1:0] tx_data,
  output logic          rx_pop,
  input  logic [DW-1:0] rx_data,
  output logic          dma_active,
  output logic          done_irq
);
  localparam int LENW  = $clog2(MAX_BURST);
  localparam int WB    = DW / 8;
  localparam int F_RDL = 1;
  localparam int F_WRL = F_RDL + LENW;
  localparam int F_RCE = F_WRL + LENW;
  localparam int F_WCE = F_RCE + 1;
  localparam logic [2:0] A_CTL = 3'd0, A_CNT = 3'd1, A_RPTR = 3'd2, A_WPTR = 3'd3, A_THR = 3'd4;

  typedef enum logic [1:0] {S_IDLE, S_RD, S_WR} st_t;

  st_t             st;
  logic            en_q, irq_q, rce_q, wce_q;
  logic [LENW-1:0] rdl_q, wrl_q, left_q;
  logic [CNTW-1:0] rcnt_q, wcnt_q;
  logic [AW-1:0]   rptr_q, wptr_q;
  logic [TW-1:0]   txthr_q, rxthr_q;

  logic ctl_wr, cnt_wr, beat, burst_end, rd_ok, wr_ok, all_done, finish;

  assign ctl_wr    = reg_wr && reg_addr == A_CTL;
  assign cnt_wr    = reg_wr && reg_addr == A_CNT;
  assign beat      = mem_req && mem_ack;
  assign burst_end = beat && left_q == '0;

  assign rd_ok = rce_q && rcnt_q != '0 && rdl_q != '0 &&
                 ({{(32-LW){1'b0}}, tx_level} < {{(32-TW){1'b0}}, txthr_q});
  assign wr_ok = wce_q && wcnt_q != '0 && wrl_q != '0 &&
                 ({{(32-LW){1'b0}}, rx_level} > {{(32-TW){1'b0}}, rxthr_q});
  assign all_done = (!rce_q || rcnt_q == '0) && (!wce_q || wcnt_q == '0);
  assign finish   = en_q && st == S_IDLE && all_done;

  assign mem_req    = st != S_IDLE;
  assign mem_we     = st == S_WR;
  assign mem_addr   = (st == S_WR) ? wptr_q : rptr_q;
  assign mem_wdata  = rx_data;
  assign tx_push    = beat && st == S_RD;
  assign tx_data    = mem_rdata;
  assign rx_pop     = beat && st == S_WR;
  assign dma_active = en_q;
  assign done_irq   = irq_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q    <= 1'b0;
      irq_q   <= 1'b0;
      rce_q   <= 1'b0;
      wce_q   <= 1'b0;
      rdl_q   <= '0;
      wrl_q   <= '0;
      rcnt_q  <= '0;
      wcnt_q  <= '0;
      rptr_q  <= '0;
      wptr_q  <= '0;
      txthr_q <= '0;
      rxthr_q <= TW'(RX_THR_RST);
    end else begin
      irq_q <= 1'b0;
      if (ctl_wr) begin
        en_q  <= reg_wdata[0];
        rdl_q <= reg_wdata[F_RDL +: LENW];
        wrl_q <= reg_wdata[F_WRL +: LENW];
        rce_q <= reg_wdata[F_RCE];
        wce_q <= reg_wdata[F_WCE];
      end else if (finish) begin
        en_q  <= 1'b0;
        irq_q <= 1'b1;
      end

      if (cnt_wr) begin
        rcnt_q <= reg_wdata[CNTW-1:0];
        wcnt_q <= reg_wdata[16 +: CNTW];
      end else if (burst_end) begin
        if (st == S_RD) rcnt_q <= rcnt_q - 1'b1;
        else            wcnt_q <= wcnt_q - 1'b1;
      end

      if (reg_wr && reg_addr == A_RPTR)  rptr_q <= reg_wdata[AW-1:0];
      else if (beat && st == S_RD)       rptr_q <= rptr_q + AW'(WB);

      if (reg_wr && reg_addr == A_WPTR)  wptr_q <= reg_wdata[AW-1:0];
      else if (beat && st == S_WR)       wptr_q <= wptr_q + AW'(WB);

      if (reg_wr && reg_addr == A_THR) begin
        txthr_q <= reg_wdata[TW-1:0];
        rxthr_q <= reg_wdata[TW +: TW];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      left_q <= '0;
    end else begin
      case (st)
        S_IDLE:
          if (en_q && wr_ok) begin
            st     <= S_WR;
            left_q <= wrl_q;
          end else if (en_q && rd_ok) begin
            st     <= S_RD;
            left_q <= rdl_q;
          end
        default:
          if (beat) begin
            if (left_q == '0 || !en_q) st <= S_IDLE;
            else                        left_q <= left_q - 1'b1;
          end
      endcase
    end
  end
endmodule

// File: rtl/spi_fifo_dma_chk.sv
module spi_fifo_dma_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          reg_wr,
  input logic          mem_req,
  input logic          mem_we,
  input logic [AW-1:0] mem_addr,
  input logic          mem_ack,
  input logic          tx_push,
  input logic          rx_pop,
  input logic          dma_active,
  input logic          done_irq
);
  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we)); // R9
  AST_PUSH_ON_READ_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    tx_push |-> mem_req && mem_ack && !mem_we); // R2
  AST_POP_ON_WRITE_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    rx_pop |-> mem_req && mem_ack && mem_we); // R3
  AST_IRQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_irq |=> !done_irq); // R8
  AST_IRQ_ENDS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    done_irq |-> !dma_active); // R8
  AST_QUIET_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !dma_active && !mem_req && !reg_wr |=> !mem_req); // R10
endmodule

bind spi_fifo_dma spi_fifo_dma_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .mem_req(mem_req), .mem_we(mem_we),
  .mem_addr(mem_addr), .mem_ack(mem_ack), .tx_push(tx_push), .rx_pop(rx_pop),
  .dma_active(dma_active), .done_irq(done_irq)
);

// File: tb/tb_spi_fifo_dma.sv
module tb_spi_fifo_dma;
  localparam int CLK_PERIOD = 10;

  typedef struct {
    bit          we;
    logic [31:0] addr;
    logic [63:0] data;
    string       tag;
  } item_t;

  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_wr = 1'b0;
  logic [2:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [4:0] tx_lvl = '0, rx_lvl = '0, tx_ld_v = '0, rx_ld_v = '0;
  logic tx_ld = 1'b0, rx_ld = 1'b0;
  logic mem_req, mem_we, mem_ack = 1'b0, tx_push, rx_pop, dma_active, done_irq;
  logic [31:0] mem_addr, rx_idx = '0;
  logic [63:0] mem_wdata, mem_rdata, tx_data, rx_data;

  item_t expq[$];
  int checks = 0, fails = 0, beats = 0, irq_seen = 0;
  bit stall = 1'b0, phase = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [63:0] memval(logic [31:0] a);
    return {32'hC0DE_0000 ^ a, a};
  endfunction

  assign mem_rdata = memval(mem_addr);
  assign rx_data   = {32'hA5A5_0000, rx_idx};

  spi_fifo_dma dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .tx_level(tx_lvl), .rx_level(rx_lvl), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack),
    .tx_push(tx_push), .tx_data(tx_data), .rx_pop(rx_pop), .rx_data(rx_data),
    .dma_active(dma_active), .done_irq(done_irq)
  );

  always @(posedge clk) begin
    if (tx_ld) tx_lvl <= tx_ld_v;
    else if (tx_push) tx_lvl <= tx_lvl + 5'd1;
    if (rx_ld) rx_lvl <= rx_ld_v;
    else if (rx_pop) rx_lvl <= rx_lvl - 5'd1;
    if (rx_pop) rx_idx <= rx_idx + 32'd1;
  end

  task automatic chk(bit ok, string req, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (done_irq) irq_seen++;
    if (mem_req) begin
      phase = !phase;
      mem_ack = !stall || phase;
    end else begin
      mem_ack = 1'b0;
    end
    if (mem_ack) begin
      #1;
      beats++;
      if (expq.size() == 0) begin
        chk(1'b0, "R9", "unexpected beat addr", 64'(mem_addr), 64'h0);
      end else begin
        item_t e;
        e = expq.pop_front();
        chk(mem_we == e.we, e.tag, "beat direction", 64'(mem_we), 64'(e.we));
        chk(mem_addr == e.addr, e.tag, "beat address", 64'(mem_addr), 64'(e.addr));
        if (e.we) chk(rx_pop && mem_wdata == e.data, e.tag, "write data", mem_wdata, e.data);
        else      chk(tx_push && tx_data == e.data, e.tag, "pushed word", tx_data, e.data);
      end
    end
  end

  task automatic push_reads(logic [31:0] a, int n, string tag);
    for (int i = 0; i < n; i++) expq.push_back('{1'b0, a + 32'(8*i), memval(a + 32'(8*i)), tag});
  endtask

  task automatic push_writes(logic [31:0] a, int n, int idx0, string tag);
    for (int i = 0; i < n; i++)
      expq.push_back('{1'b1, a + 32'(8*i), {32'hA5A5_0000, 32'(idx0 + i)}, tag});
  endtask

  task automatic wr(logic [2:0] a, logic [31:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic set_lvl(bit tx, logic [4:0] v);
    @(negedge clk);
    if (tx) begin tx_ld = 1'b1; tx_ld_v = v; end
    else    begin rx_ld = 1'b1; rx_ld_v = v; end
    @(negedge clk); tx_ld = 1'b0; rx_ld = 1'b0;
  endtask

  function automatic logic [31:0] ctl(bit en, int rdl, int wrl, bit rce, bit wce);
    return 32'(en) | 32'(rdl << 1) | 32'(wrl << 4) | (32'(rce) << 7) | (32'(wce) << 8);
  endfunction

  task automatic run_idle(string tag);
    int n = 0;
    do begin @(negedge clk); #2; n++; end while ((dma_active || mem_req) && n < 500);
    repeat (3) @(negedge clk);
    chk(!dma_active && !mem_req, tag, "run finished", 64'(dma_active), 64'h0);
    chk(expq.size() == 0, tag, "all expected beats seen", 64'(expq.size()), 64'h0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog (all requirements) act=timeout exp=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int b0, i0;
    repeat (3) @(negedge clk);
    chk(!mem_req && !dma_active && !done_irq && !tx_push && !rx_pop, "R1", "outputs in reset",
        64'({mem_req, dma_active, done_irq, tx_push, rx_pop}), 64'h0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!mem_req && !dma_active, "R1", "idle after reset", 64'({mem_req, dma_active}), 64'h0);

    // R5: default RX threshold 31 blocks a full 16-deep RX FIFO
    set_lvl(1'b0, 5'd16);
    wr(3'd1, {16'd1, 16'd0});
    wr(3'd3, 32'h2000);
    b0 = beats; i0 = irq_seen;
    wr(3'd0, ctl(1, 0, 1, 0, 1));
    repeat (20) @(negedge clk);
    chk(beats == b0, "R5", "no write burst at reset threshold", 64'(beats - b0), 64'h0);
    chk(dma_active, "R5", "engine still active", 64'(dma_active), 64'h1);
    wr(3'd0, 32'h0);
    repeat (2) @(negedge clk);
    chk(!dma_active && irq_seen == i0, "R10", "abort from idle, no irq", 64'(irq_seen - i0), 64'h0);

    // R2, R6, R7, R8: read-only run, FIFO filled by the engine itself
    set_lvl(1'b0, 5'd0);
    set_lvl(1'b1, 5'd0);
    wr(3'd4, {16'd0, 8'd31, 8'd13});
    wr(3'd1, {16'd0, 16'd3});
    wr(3'd2, 32'h1000);
    push_reads(32'h1000, 12, "R2");
    i0 = irq_seen;
    wr(3'd0, ctl(1, 3, 0, 1, 0));
    run_idle("R2");
    chk(tx_lvl == 5'd12, "R2", "TX FIFO fill", 64'(tx_lvl), 64'd12);
    chk(irq_seen == i0 + 1, "R8", "one done pulse", 64'(irq_seen - i0), 64'h1);

    // R3, R9: write run against a stalling memory
    stall = 1'b1;
    set_lvl(1'b0, 5'd8);
    wr(3'd4, {16'd0, 8'd2, 8'd0});
    wr(3'd1, {16'd2, 16'd0});
    wr(3'd3, 32'h2000);
    push_writes(32'h2000, 6, 0, "R3");
    i0 = irq_seen;
    wr(3'd0, ctl(1, 0, 2, 0, 1));
    run_idle("R3");
    chk(rx_lvl == 5'd2, "R3", "RX FIFO left at threshold", 64'(rx_lvl), 64'd2);
    chk(irq_seen == i0 + 1, "R8", "one done pulse after writes", 64'(irq_seen - i0), 64'h1);
    stall = 1'b0;

    // R2 boundary and R7 pointer carry-over
    set_lvl(1'b1, 5'd15);
    wr(3'd4, {16'd0, 8'd31, 8'd15});
    wr(3'd1, {16'd0, 16'd1});
    b0 = beats;
    wr(3'd0, ctl(1, 1, 0, 1, 0));
    repeat (20) @(negedge clk);
    chk(beats == b0, "R2", "level equal to threshold starts nothing", 64'(beats - b0), 64'h0);
    push_reads(32'h1060, 2, "R7");
    set_lvl(1'b1, 5'd14);
    run_idle("R7");
    chk(tx_lvl == 5'd16, "R7", "TX FIFO fill", 64'(tx_lvl), 64'd16);

    // R4: encoded length 0 never bursts
    set_lvl(1'b1, 5'd0);
    wr(3'd4, {16'd0, 8'd31, 8'd16});
    wr(3'd1, {16'd0, 16'd1});
    b0 = beats;
    wr(3'd0, ctl(1, 0, 0, 1, 0));
    repeat (20) @(negedge clk);
    chk(beats == b0 && dma_active, "R4", "one-word burst suppressed", 64'(beats - b0), 64'h0);
    wr(3'd0, 32'h0);
    repeat (2) @(negedge clk);
    chk(!dma_active, "R10", "abort clears enable", 64'(dma_active), 64'h0);

    // R11: both eligible, writes first
    set_lvl(1'b1, 5'd0);
    set_lvl(1'b0, 5'd10);
    wr(3'd4, {16'd0, 8'd1, 8'd15});
    wr(3'd1, {16'd1, 16'd1});
    wr(3'd2, 32'h3000);
    wr(3'd3, 32'h3800);
    push_writes(32'h3800, 2, 6, "R11");
    push_reads(32'h3000, 2, "R11");
    i0 = irq_seen;
    wr(3'd0, ctl(1, 1, 1, 1, 1));
    run_idle("R11");
    chk(irq_seen == i0 + 1, "R8", "done after both counts", 64'(irq_seen - i0), 64'h1);

    // R10: abort between acknowledgements
    stall = 1'b1;
    set_lvl(1'b0, 5'd0);
    set_lvl(1'b1, 5'd0);
    wr(3'd4, {16'd0, 8'd31, 8'd9});
    wr(3'd1, {16'd0, 16'd2});
    wr(3'd2, 32'h4000);
    push_reads(32'h4000, 3, "R10");
    b0 = beats; i0 = irq_seen;
    wr(3'd0, ctl(1, 7, 0, 1, 0));
    for (int n = 0; n < 200 && beats < b0 + 2; n++) begin @(negedge clk); #2; end
    wr(3'd0, 32'h0);
    repeat (20) @(negedge clk);
    chk(beats == b0 + 3, "R10", "beats after abort", 64'(beats - b0), 64'd3);
    chk(!dma_active && !mem_req, "R10", "quiet after abort", 64'({dma_active, mem_req}), 64'h0);
    chk(irq_seen == i0, "R10", "no irq on abort", 64'(irq_seen - i0), 64'h0);
    chk(expq.size() == 0, "R10", "expected beats consumed", 64'(expq.size()), 64'h0);
    stall = 1'b0;

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule